// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single input line. It runs from a sample enable that pulses at sixteen times the bit rate. A falling line opens a start-bit search. A qualified start bit is followed by the data bits, least significant first, then an optional parity bit, then one stop bit. Each bit value is the two-of-three majority of samples taken in the middle of the bit. A finished character is moved into a data register, and a status register reports what happened to it.

Software reads both registers over a minimal read port: a select and a read strobe, with read data returned in the same cycle. The error flags and the receive-full flag are cleared by a two-step sequence. A status read first records which flags it saw set. A later data read then clears exactly those flags. A framing error stops the receiver from starting new characters until that sequence has cleared it. A separate receiver-active flag shows when a start bit has been seen and a frame may be in progress.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the status register reads 0 and the data register reads 0.
- R2: A frame is a 0 start bit, DATA_BITS data bits sent least significant first, a parity bit when parityEn is 1, and a stop bit. When the stop bit has been sampled and the receive-full flag (status bit 4) was clear, the data register takes the data bits and the receive-full flag is set.
- R3: Each bit is sampled at sample times 8, 9 and 10 of its sixteen, and its value is the two-of-three majority. A start bit is sampled at times 3, 5 and 7. Any disagreement among the three samples of any bit in the frame sets the noise flag (status bit 2) when the character is loaded. A sample at any other time has no effect.
- R4: With parityEn = 1, the parity-error flag (status bit 0) is set when the XOR of the data bits and the received parity bit differs from parityOdd (0 selects even, 1 selects odd). With parityEn = 0 it is never set.
- R5: The framing-error flag (status bit 1) is set, together with receive-full, when the stop bit is sampled as 0.
- R6: While the framing-error flag is set, no start bit is accepted. Reception resumes once the flag is cleared.
- R7: If a frame completes while receive-full is set, the overrun flag (status bit 3) is set, the new character is dropped and the data register keeps its value.
- R8: A frame that causes an overrun sets none of the noise, framing-error or parity-error flags.
- R9: A read with regSel = 0 returns the status and arms every flag that it sees set. The next read with regSel = 1 returns the data and clears the armed flags. A data read with nothing armed clears nothing.
- R10: A flag that becomes set after the arming status read is not cleared by the following data read.
- R11: The receiver-active flag (status bit 5) is set at the first sample that sees the line at 0 during the start-bit search.
- R12: If the majority of the start-bit samples is 1, the start is false: receiver-active is cleared, no character is loaded, and the search starts again.
- R13: Receiver-active is cleared after the line has stayed at 1 in the search state for one frame time: DATA_BITS+2 bit times without parity, DATA_BITS+3 bit times with parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Sample enable at sixteen times the bit rate |
| rxLine | input | 1 | Serial input line, idle at 1 |
| parityEn | input | 1 | 1 adds a parity bit to each frame |
| parityOdd | input | 1 | Parity sense: 0 even, 1 odd |
| rdEn | input | 1 | Read strobe; the clear side effects take place at the clock edge |
| regSel | input | 1 | 0 selects status, 1 selects data |
| rdData | output | RD_W | Selected register, zero-extended. Status: bit5 active, bit4 full, bit3 overrun, bit2 noise, bit1 framing, bit0 parity |

## Verification
The bench builds the block with DATA_BITS = 8 and SYNC_STAGES = 2, and holds sampleTick high so that every bit lasts exactly sixteen clocks. At that rate all 256 character codes can be received with parity off, and a spread of codes in both parity senses with both correct and corrupted parity bits, within the run. Because bit timing is fixed to the clock, single-clock glitches can be placed on exact sample slots. The idle-character window can be timed to a few clocks, which separates the ten-bit frame length from the eleven-bit one.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Bit positions inside the status word
  localparam int F_PAR  = 0;
  localparam int F_FRM  = 1;
  localparam int F_NOI  = 2;
  localparam int F_OVR  = 3;
  localparam int F_FULL = 4;
  localparam int F_ACT  = 5;
  localparam int STAT_W = 6;

  typedef enum logic [2:0] {
    S_SEARCH,
    S_START,
    S_DATA,
    S_PARITY,
    S_STOP
  } rx_state_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic frameStart;  // start sample seen, frame opens
    logic activeClr;   // false start or idle character
    logic shiftEn;     // data bit decided
    logic bitVal;      // decided value of the current bit
    logic bitNoise;    // three samples disagreed
    logic parityCap;   // parity bit decided
    logic frameDone;   // stop bit decided
    logic stopBad;     // stop bit sampled as 0
  } rx_strobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic       parityEn,
  input  logic       inhibit,
  output rx_strobe_t strb
);

  localparam int BIT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int LIM_NP = (DATA_BITS + 2) * 16;
  localparam int LIM_P  = (DATA_BITS + 3) * 16;
  localparam int IDLE_W = $clog2(LIM_P + 1);

  // Input synchroniser chain; zero stages is a plain wire
  logic [SYNC_STAGES:0] chain;
  assign chain[0] = rxLine;
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i+1] <= 1'b1;
      else       chain[i+1] <= chain[i];
    end
  end
  logic rxS;
  assign rxS = chain[SYNC_STAGES];

  rx_state_t         state, stateN;
  logic [3:0]        cnt, cntN;
  logic [BIT_W-1:0]  bitIdx, bitIdxN;
  logic [IDLE_W-1:0] idleCnt, idleN;
  logic              v0, v1, v0N, v1N;

  logic [4:0]        sampleNo;
  logic [4:0]        firstPt, secondPt, decidePt;
  logic              maj, dis;
  logic [IDLE_W-1:0] idleLim;

  assign sampleNo = {1'b0, cnt} + 5'd1;
  assign firstPt  = (state == S_START) ? 5'd3 : 5'd8;
  assign secondPt = (state == S_START) ? 5'd5 : 5'd9;
  assign decidePt = (state == S_START) ? 5'd7 : 5'd10;
  assign maj      = (v0 & v1) | (v0 & rxS) | (v1 & rxS);
  assign dis      = !((v0 == v1) && (v1 == rxS));
  assign idleLim  = parityEn ? IDLE_W'(LIM_P) : IDLE_W'(LIM_NP);

  always_comb begin
    strb    = '0;
    stateN  = state;
    cntN    = cnt;
    bitIdxN = bitIdx;
    idleN   = idleCnt;
    v0N     = v0;
    v1N     = v1;
    if (sampleTick) begin
      if (state == S_SEARCH) begin
        cntN = '0;
        if (!rxS && !inhibit) begin
          strb.frameStart = 1'b1;
          stateN = S_START;
          cntN   = 4'd1;
          idleN  = '0;
        end else if (!rxS) begin
          idleN = '0;
        end else if (idleCnt < idleLim) begin
          idleN = idleCnt + 1'b1;
          if (idleCnt == idleLim - 1'b1) strb.activeClr = 1'b1;
        end
      end else begin
        cntN = cnt + 4'd1;
        if (sampleNo == firstPt)  v0N = rxS;
        if (sampleNo == secondPt) v1N = rxS;
        if (sampleNo == decidePt) begin
          strb.bitNoise = dis;
          strb.bitVal   = maj;
          case (state)
            S_START: if (maj) begin
              stateN = S_SEARCH;
              strb.activeClr = 1'b1;
              idleN = '0;
            end
            S_DATA:   strb.shiftEn   = 1'b1;
            S_PARITY: strb.parityCap = 1'b1;
            S_STOP: begin
              strb.frameDone = 1'b1;
              strb.stopBad   = !maj;
              stateN = S_SEARCH;
              idleN  = '0;
            end
            default: ;
          endcase
        end
        if (sampleNo == 5'd16) begin
          case (state)
            S_START: begin
              stateN  = S_DATA;
              bitIdxN = '0;
            end
            S_DATA: begin
              if (bitIdx == BIT_W'(DATA_BITS - 1))
                stateN = parityEn ? S_PARITY : S_STOP;
              else
                bitIdxN = bitIdx + 1'b1;
            end
            S_PARITY: stateN = S_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_SEARCH;
      cnt     <= '0;
      bitIdx  <= '0;
      idleCnt <= '0;
      v0      <= 1'b1;
      v1      <= 1'b1;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      bitIdx  <= bitIdxN;
      idleCnt <= idleN;
      v0      <= v0N;
      v1      <= v1N;
    end
  end

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int RD_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rx_strobe_t           strb,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 rdEn,
  input  logic                 regSel,
  output logic [RD_W-1:0]      rdData,
  output logic [STAT_W-1:0]    statusWord,
  output logic [DATA_BITS-1:0] dataReg,
  output logic                 inhibit
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 noiseAcc, parBit, active;
  logic [4:0]           flags, flagsN, armed, armedN;
  logic                 loadData, noiseNow, parityBad;

  assign noiseNow  = noiseAcc | strb.bitNoise;
  assign parityBad = parityEn && ((^shiftReg ^ parBit) != parityOdd);

  always_comb begin
    flagsN   = flags;
    armedN   = armed;
    loadData = 1'b0;
    if (rdEn && !regSel) armedN = flags;
    if (rdEn && regSel) begin
      flagsN = flags & ~armed;
      armedN = '0;
    end
    if (strb.frameDone) begin
      if (flags[F_FULL]) begin
        flagsN[F_OVR] = 1'b1;
      end else begin
        loadData       = 1'b1;
        flagsN[F_FULL] = 1'b1;
        if (strb.stopBad) flagsN[F_FRM] = 1'b1;
        if (noiseNow)     flagsN[F_NOI] = 1'b1;
        if (parityBad)    flagsN[F_PAR] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      noiseAcc <= 1'b0;
      parBit   <= 1'b0;
      dataReg  <= '0;
      flags    <= '0;
      armed    <= '0;
      active   <= 1'b0;
    end else begin
      flags <= flagsN;
      armed <= armedN;
      if (loadData) dataReg <= shiftReg;
      if (strb.frameStart) begin
        shiftReg <= '0;
        noiseAcc <= 1'b0;
        parBit   <= 1'b0;
      end else begin
        if (strb.bitNoise)  noiseAcc <= 1'b1;
        if (strb.shiftEn)   shiftReg <= {strb.bitVal, shiftReg[DATA_BITS-1:1]};
        if (strb.parityCap) parBit   <= strb.bitVal;
      end
      if (strb.frameStart)     active <= 1'b1;
      else if (strb.activeClr) active <= 1'b0;
    end
  end

  assign statusWord = {active, flags};
  assign inhibit    = flags[F_FRM];
  assign rdData     = regSel ? RD_W'(dataReg) : RD_W'(statusWord);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int RD_W = (DATA_BITS > STAT_W) ? DATA_BITS : STAT_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleTick,
  input  logic            rxLine,
  input  logic            parityEn,
  input  logic            parityOdd,
  input  logic            rdEn,
  input  logic            regSel,
  output logic [RD_W-1:0] rdData
);

  rx_strobe_t           strb;
  logic [STAT_W-1:0]    statusWord;
  logic [DATA_BITS-1:0] dataReg;
  logic                 inhibit;

  uart_rx_ctrl #(.DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .parityEn(parityEn), .inhibit(inhibit), .strb(strb)
  );

  uart_rx_dp #(.DATA_BITS(DATA_BITS), .RD_W(RD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .parityEn(parityEn),
    .parityOdd(parityOdd), .rdEn(rdEn), .regSel(regSel), .rdData(rdData),
    .statusWord(statusWord), .dataReg(dataReg), .inhibit(inhibit)
  );

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic                 regSel,
  input logic                 parityEn,
  input rx_strobe_t           strb,
  input logic [STAT_W-1:0]    statusWord,
  input logic [DATA_BITS-1:0] dataReg
);

  p_load_on_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone && !statusWord[F_FULL] |=> statusWord[F_FULL]);

  p_parity_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[F_PAR]) |-> $past(parityEn));

  p_frame_err_blocks_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[F_FRM] |-> !strb.frameStart);

  p_overrun_keeps_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone && statusWord[F_FULL] |=>
      statusWord[F_OVR] && (dataReg == $past(dataReg)));

  p_overrun_no_errors_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone && statusWord[F_FULL] |=>
      (!statusWord[F_NOI] || $past(statusWord[F_NOI])) &&
      (!statusWord[F_FRM] || $past(statusWord[F_FRM])) &&
      (!statusWord[F_PAR] || $past(statusWord[F_PAR])));

  p_full_clears_on_data_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusWord[F_FULL]) |-> $past(rdEn && regSel));

  p_active_on_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> statusWord[F_ACT]);

  // R12 and R13 share the clearing path
  p_active_clear_r13: assert property (@(posedge clk) disable iff (!rstN)
    strb.activeClr && !strb.frameStart |=> !statusWord[F_ACT]);

endmodule

bind uart_rx_core uart_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .regSel(regSel), .parityEn(parityEn),
  .strb(strb), .statusWord(statusWord), .dataReg(dataReg)
);

// File: tb/uart_rx_core_bench.sv
`timescale 1ns/1ps
module uart_rx_core_bench;

  localparam logic [7:0] ACT = 8'h20, FULL = 8'h10, OVR = 8'h08,
                         NOI = 8'h04, FRM = 8'h02, PAR = 8'h01;

  logic clk = 1'b0, rstN = 1'b0, sampleTick = 1'b1, rxLine = 1'b1;
  logic parityEn = 1'b0, parityOdd = 1'b0, rdEn = 1'b0, regSel = 1'b0;
  logic [7:0] rdData;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_core #(.DATA_BITS(8), .SYNC_STAGES(2)) u_uart_rx_core (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .parityEn(parityEn), .parityOdd(parityOdd), .rdEn(rdEn),
    .regSel(regSel), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk); regSel = sel; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(input logic sel, output logic [7:0] v);
    @(negedge clk); regSel = sel; rdEn = 1'b0;
    #1 v = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit flipPar, input bit stopV,
                           input int gBit, input int gC);
    int nb;
    nb = parityEn ? 11 : 10;
    for (int b = 0; b < nb; b++) begin
      logic v;
      if (b == 0)                      v = 1'b0;
      else if (b <= 8)                 v = d[b-1];
      else if (parityEn && b == 9)     v = (^d) ^ parityOdd ^ flipPar;
      else                             v = stopV;
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rxLine = (b == gBit && c == gC) ? ~v : v;
      end
    end
    for (int g = 0; g < 4; g++) begin
      @(negedge clk); rxLine = 1'b1;
    end
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    peek(1'b0, v); chk("R1 status", v, 8'h00);
    peek(1'b1, v); chk("R1 data", v, 8'h00);

    // R2 every code, no parity, with the R9 clear sequence
    parityEn = 1'b0;
    for (int i = 0; i < 256; i++) begin
      sendFrame(8'(i), 0, 1, -1, 0);
      rd(1'b0, v); chk("R2 status after frame", v, ACT | FULL);
      rd(1'b1, v); chk("R2 data", v, 8'(i));
      peek(1'b0, v); chk("R9 status after clear", v, ACT);
    end

    // R4 parity in both senses, correct and corrupted
    parityEn = 1'b1;
    for (int m = 0; m < 2; m++) begin
      parityOdd = m[0];
      for (int i = 0; i < 32; i++) begin
        d = 8'((i * 37 + 5) & 255);
        sendFrame(d, 0, 1, -1, 0);
        rd(1'b0, v); chk("R4 good parity status", v, ACT | FULL);
        rd(1'b1, v); chk("R4 good parity data", v, d);
        sendFrame(d, 1, 1, -1, 0);
        rd(1'b0, v); chk("R4 bad parity status", v, ACT | FULL | PAR);
        rd(1'b1, v); chk("R4 bad parity data", v, d);
        peek(1'b0, v); chk("R4 cleared", v, ACT);
      end
    end
    parityOdd = 1'b0;

    // R9 data read without status read clears nothing
    parityEn = 1'b0;
    sendFrame(8'h5A, 0, 1, -1, 0);
    rd(1'b1, v); chk("R9 data", v, 8'h5A);
    peek(1'b0, v); chk("R9 unarmed read keeps flags", v, ACT | FULL);
    rd(1'b0, v); rd(1'b1, v);
    peek(1'b0, v); chk("R9 armed clear", v, ACT);

    // R7 and R10 overrun after arming
    sendFrame(8'h11, 0, 1, -1, 0);
    rd(1'b0, v); chk("R10 arm status", v, ACT | FULL);
    sendFrame(8'h22, 0, 1, -1, 0);
    peek(1'b0, v); chk("R7 overrun status", v, ACT | FULL | OVR);
    rd(1'b1, v); chk("R7 data kept", v, 8'h11);
    peek(1'b0, v); chk("R10 late flag survives", v, ACT | OVR);
    rd(1'b0, v); rd(1'b1, v);
    peek(1'b0, v); chk("R10 overrun cleared", v, ACT);

    // R8 errors suppressed on an overrun frame
    parityEn = 1'b1;
    sendFrame(8'h3C, 0, 1, -1, 0);
    sendFrame(8'hC3, 1, 1, 3, 8);
    peek(1'b0, v); chk("R8 overrun without errors", v, ACT | FULL | OVR);
    rd(1'b0, v); rd(1'b1, v); chk("R7 data after overrun", v, 8'h3C);
    peek(1'b0, v); chk("R8 cleared", v, ACT);

    // R3 noise and majority
    parityEn = 1'b0;
    sendFrame(8'h96, 0, 1, 5, 8);
    rd(1'b0, v); chk("R3 data glitch noise", v, ACT | FULL | NOI);
    rd(1'b1, v); chk("R3 majority data", v, 8'h96);
    sendFrame(8'h69, 0, 1, 0, 4);
    rd(1'b0, v); chk("R3 start glitch noise", v, ACT | FULL | NOI);
    rd(1'b1, v); chk("R3 start glitch data", v, 8'h69);
    sendFrame(8'hF0, 0, 1, 2, 6);
    rd(1'b0, v); chk("R3 off-window glitch ignored", v, ACT | FULL);
    rd(1'b1, v); chk("R3 off-window data", v, 8'hF0);

    // R5 and R6 framing error and inhibit
    sendFrame(8'hA5, 0, 0, -1, 0);
    peek(1'b0, v); chk("R5 framing flag", v, ACT | FULL | FRM);
    sendFrame(8'h0F, 0, 1, -1, 0);
    peek(1'b0, v); chk("R6 no start while framing set", v, ACT | FULL | FRM);
    peek(1'b1, v); chk("R6 data unchanged", v, 8'hA5);
    rd(1'b0, v); rd(1'b1, v);
    peek(1'b0, v); chk("R6 framing cleared", v, ACT);
    sendFrame(8'h0F, 0, 1, -1, 0);
    rd(1'b0, v); chk("R6 reception resumes", v, ACT | FULL);
    rd(1'b1, v); chk("R6 resumed data", v, 8'h0F);

    // R13 idle character, ten-bit frame
    sendFrame(8'h42, 0, 1, -1, 0);
    idle(130);
    peek(1'b0, v); chk("R13 active before idle frame", v, ACT | FULL);
    idle(30);
    peek(1'b0, v); chk("R13 active cleared 10 bits", v, FULL);
    rd(1'b0, v); rd(1'b1, v);

    // R13 idle character, eleven-bit frame
    parityEn = 1'b1;
    sendFrame(8'h24, 0, 1, -1, 0);
    idle(160);
    peek(1'b0, v); chk("R13 active kept past 10 bits", v, ACT | FULL);
    idle(20);
    peek(1'b0, v); chk("R13 active cleared 11 bits", v, FULL);
    rd(1'b0, v); rd(1'b1, v);
    peek(1'b0, v); chk("R13 all clear", v, 8'h00);

    // R11 and R12 false start
    parityEn = 1'b0;
    @(negedge clk); rxLine = 1'b0;
    @(negedge clk);
    @(negedge clk); rxLine = 1'b1;
    idle(3);
    peek(1'b0, v); chk("R11 active at start sample", v, ACT);
    idle(10);
    peek(1'b0, v); chk("R12 false start dropped", v, 8'h00);
    peek(1'b1, v); chk("R12 data unchanged", v, 8'h24);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule